// File: doc/BRIEF.md
# Accumulator Processor with Multicycle Control

This block is a compact 16-bit processor built around a single accumulator. One memory port serves both instruction fetches and operand traffic. A program counter, an instruction register, a memory-data register, the accumulator and two status flags (negative and zero) make up the datapath. A Moore-style controller steps every instruction through an initialise state, a two-state fetch, a decode state and an execute path. The execute path depends on the instruction class.

Each instruction names at most one memory word. Arithmetic and logic operations take the accumulator as their first operand and write their result back to it. Loads and stores move a word between memory and the accumulator. Jumps and conditional branches redirect the program counter using the address field of the instruction.

The memory is synchronous-read with one cycle of latency. For that reason, every memory read spends one state driving the address and one state capturing the returned word. The surrounding system supplies that memory, loads a program into it and releases reset. Results are observed as memory writes.

Top module: `acc_cpu`

## Requirements
- R1: While reset is high and in the cycle after it, `mem_we` and `halted` are 0 and `mem_addr` is 0. Reset clears the program counter and the accumulator to zero, so a STORE at address 0 writes 0x0000.
- R2: An instruction word holds its opcode in bits [15:12] and a 12-bit address or branch target in bits [11:0]. The opcodes are 0 ADD, 1 SUB, 2 AND, 3 OR, 4 LOAD, 5 STORE, 6 JMP, 7 BRZ, 8 BRN and F HALT.
- R3: ADD, SUB, AND and OR replace the accumulator with the accumulator combined with the word at the address field. ADD and SUB wrap modulo 2^16.
- R4: LOAD copies the addressed word into the accumulator. STORE drives the accumulator on `mem_wdata` with `mem_we` high for exactly one cycle at the address field, and it leaves the accumulator unchanged.
- R5: JMP always loads the program counter from the address field.
- R6: BRZ jumps when the zero flag is set and BRN jumps when the negative flag is set. Otherwise each continues at the next address.
- R7: The zero flag (result equals 0) and the negative flag (result bit 15) change only when an ALU or LOAD result is written to the accumulator. STORE and branches leave both flags as they were.
- R8: Opcodes 9 through E do nothing except advance the program counter by one.
- R9: After HALT, `halted` stays 1 until reset, no memory write occurs and `mem_addr` holds still.
- R10: A STORE takes four cycles: fetch address, fetch capture, decode and write. With a STORE at address 0, `mem_we` rises on the fourth rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory word address, taken from the program counter or the instruction address field |
| mem_wdata | output | 16 | Accumulator value to be written |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 16 | Word read from memory, valid one cycle after its address |
| halted | output | 1 | High once a HALT has executed |

## Verification
A single program is run twice, with reset applied while the core is halted. The second run shows that reset clears the accumulator and restarts fetching at address 0. The program mixes all four ALU operations with wrapping and sign-crossing operands: 0xFFFF + 1 gives zero, and 0x7FFF + 1 gives a negative result. Each conditional branch is exercised both taken and not taken. A STORE sits between a flag-setting operation and the branch that tests it, which separates correct flag retention from flags disturbed by stores. Undefined opcodes and skipped STOREs on wrong paths leave traces in the write stream if they misbehave, and the write stream is compared in order against an expected list.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
    parameter int DATA_W = 16;
    parameter int ADDR_W = 12;
    localparam int OPC_W = DATA_W - ADDR_W;

    typedef enum logic [OPC_W-1:0] {
        OPC_ADD   = 4'h0,
        OPC_SUB   = 4'h1,
        OPC_AND   = 4'h2,
        OPC_OR    = 4'h3,
        OPC_LOAD  = 4'h4,
        OPC_STORE = 4'h5,
        OPC_JMP   = 4'h6,
        OPC_BRZ   = 4'h7,
        OPC_BRN   = 4'h8,
        OPC_HALT  = 4'hF
    } opcode_e;

    typedef enum logic [3:0] {
        ST_INIT, ST_FETCH_A, ST_FETCH_D, ST_DECODE,
        ST_OPER_A, ST_OPER_D, ST_EXEC, ST_STORE,
        ST_BRANCH, ST_HALT
    } state_e;

    typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_PASS} alu_op_e;

    typedef enum logic [1:0] {CLS_ALU, CLS_STORE, CLS_FLOW, CLS_HALT} iclass_e;

    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    typedef struct packed {
        logic ir_ld;
        logic mdr_ld;
        logic ac_ld;
        logic pc_inc;
        logic pc_jump;
        logic addr_ir;
        logic mem_we;
    } ctrl_t;

    function automatic iclass_e classify(logic [OPC_W-1:0] opc);
        case (opc)
            OPC_ADD, OPC_SUB, OPC_AND, OPC_OR, OPC_LOAD: return CLS_ALU;
            OPC_STORE: return CLS_STORE;
            OPC_HALT:  return CLS_HALT;
            default:   return CLS_FLOW;
        endcase
    endfunction

    function automatic alu_op_e alu_sel(logic [OPC_W-1:0] opc);
        case (opc)
            OPC_ADD: return ALU_ADD;
            OPC_SUB: return ALU_SUB;
            OPC_AND: return ALU_AND;
            OPC_OR:  return ALU_OR;
            default: return ALU_PASS;
        endcase
    endfunction
endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  alu_op_e           op,
    output logic [DATA_W-1:0] res,
    output logic              neg,
    output logic              zero
);
    always_comb begin
        unique case (op)
            ALU_ADD:  res = a + b;
            ALU_SUB:  res = a + ~b + DATA_W'(1);
            ALU_AND:  res = a & b;
            ALU_OR:   res = a | b;
            default:  res = b;
        endcase
        neg  = res[DATA_W-1];
        zero = (res == '0);
    end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opc,
    input  logic             flag_n,
    input  logic             flag_z,
    output ctrl_t            ctl,
    output logic             halted
);
    state_e st, nx;
    logic   take;

    always_ff @(posedge clk) begin
        if (rst) st <= ST_INIT;
        else     st <= nx;
    end

    always_comb begin
        nx   = st;
        ctl  = '0;
        take = (opc == OPC_JMP) ||
               ((opc == OPC_BRZ) && flag_z) ||
               ((opc == OPC_BRN) && flag_n);
        unique case (st)
            ST_INIT:    nx = ST_FETCH_A;
            ST_FETCH_A: nx = ST_FETCH_D;
            ST_FETCH_D: begin ctl.ir_ld = 1'b1; nx = ST_DECODE; end
            ST_DECODE: begin
                unique case (classify(opc))
                    CLS_ALU:   nx = ST_OPER_A;
                    CLS_STORE: nx = ST_STORE;
                    CLS_FLOW:  nx = ST_BRANCH;
                    default:   nx = ST_HALT;
                endcase
            end
            ST_OPER_A:  begin ctl.addr_ir = 1'b1; nx = ST_OPER_D; end
            ST_OPER_D:  begin ctl.mdr_ld = 1'b1; nx = ST_EXEC; end
            ST_EXEC:    begin ctl.ac_ld = 1'b1; ctl.pc_inc = 1'b1; nx = ST_FETCH_A; end
            ST_STORE: begin
                ctl.addr_ir = 1'b1;
                ctl.mem_we  = 1'b1;
                ctl.pc_inc  = 1'b1;
                nx = ST_FETCH_A;
            end
            ST_BRANCH: begin
                ctl.pc_jump = take;
                ctl.pc_inc  = !take;
                nx = ST_FETCH_A;
            end
            default:    nx = ST_HALT;
        endcase
    end

    assign halted = (st == ST_HALT);

    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !ctl.mem_we));
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted
);
    logic [ADDR_W-1:0] pc;
    instr_t            ir;
    logic [DATA_W-1:0] mdr, ac, alu_res;
    logic              fn, fz, alu_n, alu_z;
    ctrl_t             ctl;

    acc_cpu_ctrl u_ctrl (
        .clk(clk), .rst(rst), .opc(ir.opc),
        .flag_n(fn), .flag_z(fz), .ctl(ctl), .halted(halted)
    );

    acc_cpu_alu u_alu (
        .a(ac), .b(mdr), .op(alu_sel(ir.opc)),
        .res(alu_res), .neg(alu_n), .zero(alu_z)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            ir  <= '0;
            mdr <= '0;
            ac  <= '0;
            fn  <= 1'b0;
            fz  <= 1'b0;
        end else begin
            if (ctl.ir_ld)  ir  <= instr_t'(mem_rdata);
            if (ctl.mdr_ld) mdr <= mem_rdata;
            if (ctl.ac_ld) begin
                ac <= alu_res;
                fn <= alu_n;
                fz <= alu_z;
            end
            if (ctl.pc_jump)     pc <= ir.addr;
            else if (ctl.pc_inc) pc <= pc + ADDR_W'(1);
        end
    end

    assign mem_addr  = ctl.addr_ir ? ir.addr : pc;
    assign mem_wdata = ac;
    assign mem_we    = ctl.mem_we;

    // R4
    we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl.ac_ld |=> $stable({fn, fz}));

    // R5
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.pc_jump |=> (pc == $past(ir.addr)));
endmodule

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;
    import acc_cpu_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_we;
    logic [DATA_W-1:0] mem_rdata;
    logic              halted;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [DATA_W-1:0] ram [256];
    logic [ADDR_W-1:0] q_addr [$];
    logic [DATA_W-1:0] q_data [$];
    string             q_tag  [$];

    always #10 clk = ~clk;

    acc_cpu dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted)
    );

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= ram[mem_addr[7:0]];
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input string tag);
        q_addr.push_back(a);
        q_data.push_back(d);
        q_tag.push_back(tag);
    endtask

    // monitor: compare every write against the scoreboard
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (q_addr.size() == 0) begin
                check(0, "R9 unexpected write", {4'h0, mem_addr, mem_wdata}, 0);
            end else begin
                logic [ADDR_W-1:0] ea;
                logic [DATA_W-1:0] ed;
                string             et;
                ea = q_addr.pop_front();
                ed = q_data.pop_front();
                et = q_tag.pop_front();
                check(mem_addr == ea && mem_wdata == ed, et,
                      {4'h0, mem_addr, mem_wdata}, {4'h0, ea, ed});
            end
        end
    end

    function automatic logic [15:0] ins(input logic [3:0] opc, input logic [11:0] a);
        return {opc, a};
    endfunction

    task automatic load_program();
        for (int i = 0; i < 256; i++) ram[i] = 16'h0000;
        ram[8'h80] = 16'h0005; ram[8'h81] = 16'h0003; ram[8'h82] = 16'hFFFF;
        ram[8'h83] = 16'h00F0; ram[8'h85] = 16'h7FFF; ram[8'h86] = 16'h0001;
        ram[8'h00] = ins(4'h5, 12'h0A0);
        ram[8'h01] = ins(4'h4, 12'h080);
        ram[8'h02] = ins(4'h0, 12'h081);
        ram[8'h03] = ins(4'h5, 12'h0A1);
        ram[8'h04] = ins(4'h1, 12'h082);
        ram[8'h05] = ins(4'h5, 12'h0A2);
        ram[8'h06] = ins(4'h2, 12'h083);
        ram[8'h07] = ins(4'h5, 12'h0A3);
        ram[8'h08] = ins(4'h7, 12'h00B);
        ram[8'h09] = ins(4'h5, 12'h0AF);
        ram[8'h0A] = ins(4'hF, 12'h000);
        ram[8'h0B] = ins(4'h3, 12'h081);
        ram[8'h0C] = ins(4'h7, 12'h009);
        ram[8'h0D] = ins(4'h5, 12'h0A4);
        ram[8'h0E] = ins(4'h4, 12'h082);
        ram[8'h0F] = ins(4'h8, 12'h012);
        ram[8'h10] = ins(4'h5, 12'h0AF);
        ram[8'h11] = ins(4'hF, 12'h000);
        ram[8'h12] = ins(4'h0, 12'h086);
        ram[8'h13] = ins(4'h5, 12'h0A5);
        ram[8'h14] = ins(4'h8, 12'h010);
        ram[8'h15] = ins(4'h9, 12'h0AF);
        ram[8'h16] = ins(4'h4, 12'h085);
        ram[8'h17] = ins(4'h0, 12'h086);
        ram[8'h18] = ins(4'h5, 12'h0A6);
        ram[8'h19] = ins(4'h6, 12'h01C);
        ram[8'h1A] = ins(4'h5, 12'h0AF);
        ram[8'h1B] = ins(4'hF, 12'h000);
        ram[8'h1C] = ins(4'hE, 12'h0AF);
        ram[8'h1D] = ins(4'h5, 12'h0A7);
        ram[8'h1E] = ins(4'hF, 12'h000);
    endtask

    task automatic push_expected();
        expect_wr(12'h0A0, 16'h0000, "R1 reset AC store");
        expect_wr(12'h0A1, 16'h0008, "R3 ADD after LOAD");
        expect_wr(12'h0A2, 16'h0009, "R3 SUB of -1");
        expect_wr(12'h0A3, 16'h0000, "R3 AND to zero");
        expect_wr(12'h0A4, 16'h0003, "R6 BRZ taken then not taken");
        expect_wr(12'h0A5, 16'h0000, "R6 BRN taken, R3 wrap to zero");
        expect_wr(12'h0A6, 16'h8000, "R8 no-op, R2 sign crossing");
        expect_wr(12'h0A7, 16'h8000, "R5 JMP, R4 AC kept by STORE");
    endtask

    task automatic run_to_halt(input string tag);
        int cyc;
        cyc = 0;
        while (!halted && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        check(halted == 1'b1, {tag, " R9 halt reached"}, halted, 1);
        begin
            logic [ADDR_W-1:0] a0;
            bit                steady;
            a0     = mem_addr;
            steady = 1;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (mem_addr != a0 || mem_we || !halted) steady = 0;
            end
            check(steady, {tag, " R9 halted and quiet"}, steady, 1);
        end
        check(q_addr.size() == 0, {tag, " R7 all writes seen"}, q_addr.size(), 0);
    endtask

    initial begin
        int cnt;
        load_program();
        push_expected();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(mem_we == 1'b0 && halted == 1'b0 && mem_addr == '0, "R1 reset outputs",
              {mem_we, halted, mem_addr}, 0);
        rst = 1'b0;
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (cnt == 1)
                check(mem_addr == '0, "R1 first fetch at zero", mem_addr, 0);
            if (mem_we) break;
        end
        // R10 store timing
        check(cnt == 4, "R10 first store edge", cnt, 4);
        run_to_halt("run1");

        // reset while halted: AC and PC must clear again
        push_expected();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(halted == 1'b0 && mem_we == 1'b0, "R1 reset leaves halt", halted, 0);
        @(negedge clk);
        rst = 1'b0;
        run_to_halt("run2");
        done = 1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=halted");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule